// File: doc/BRIEF.md
# Display RAM Write Address Generator

This block produces the byte address and write strobe for a monochrome display memory of 8 pages by 128 columns, 1024 bytes in all. Each byte in the memory holds one column's worth of 8 vertically stacked pixels within one page. Two pointers are kept, one for the column and one for the page. Each pointer moves inside its own window, whose first and last values are programmable. Each accepted data byte is written at the current address. The pointers then step.

Two scan orders are supported. In row order the column pointer steps first, and the page pointer advances when the column pointer wraps. In column order the page pointer steps first, and the column pointer advances when the page pointer wraps. Data bytes arrive on a valid/ready stream and leave on a plain write port in the same cycle.

The stream applies back-pressure only while a configuration strobe is high. In that cycle `wr_ready` is low and a presented byte waits. No byte is ever dropped or duplicated.

Top module: `disp_wr_addr_gen`

## Requirements
- R1: When `wr_valid` and `wr_ready` are both high, `ram_we` is high in the same cycle, `ram_wdata` equals `wr_data`, and `ram_addr` equals page*128 + column, with the page in bits [9:7] and the column in bits [6:0].
- R2: A cycle with `col_set` high stores `col_start` and `col_end` as the column window and moves the column pointer to `col_start` for the next cycle.
- R3: A cycle with `pg_set` high stores `pg_start` and `pg_end` as the page window and moves the page pointer to `pg_start` for the next cycle.
- R4: In row order, each written byte advances the column pointer by one. A column pointer that sits on its window end returns to the window start instead, and the page pointer then takes one step.
- R5: In column order, each written byte advances the page pointer by one. A page pointer that sits on its window end returns to the window start instead, and the column pointer then takes one step.
- R6: When a byte is written with both pointers on their window ends, both pointers return to their window starts.
- R7: A cycle with `mode_set` high and `mode_sel` = 0 selects row order, and `mode_sel` = 1 selects column order. Values 2 and 3 leave the current order unchanged.
- R8: After reset the order is row order, the column window is 0 to 127, the page window is 0 to 7, and both pointers are 0.
- R9: While any of `col_set`, `pg_set` or `mode_set` is high, `wr_ready` is low, `ram_we` stays low and the presented byte does not advance the pointers. Outside such cycles `wr_ready` is high.
- R10: In a cycle with no written byte and no window load, the address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_set | input | 1 | Load the column window and the column pointer |
| col_start | input | 7 | First column of the window |
| col_end | input | 7 | Last column of the window |
| pg_set | input | 1 | Load the page window and the page pointer |
| pg_start | input | 3 | First page of the window |
| pg_end | input | 3 | Last page of the window |
| mode_set | input | 1 | Load the scan order |
| mode_sel | input | 2 | Scan order: 0 row order, 1 column order |
| wr_valid | input | 1 | Data byte present |
| wr_ready | output | 1 | Byte can be taken this cycle |
| wr_data | input | 8 | Pixel byte |
| ram_we | output | 1 | Write strobe to the display memory |
| ram_addr | output | 10 | Byte address, page*128 + column |
| ram_wdata | output | 8 | Byte to write |

## Verification
A full-screen run in row order walks all 1024 addresses and ends back at zero. This separates a correct column-to-page carry from an off-by-one at column 127 or page 7. A small window in both orders, such as columns 10 to 13 with pages 2 to 3, or columns 120 to 127 with pages 5 to 7, shows whether wraps return to the programmed start rather than to zero and whether the right pointer carries. A single-address window, an unsupported mode code, idle gaps between bytes and bytes presented during configuration strobes separate the double-wrap, ignore, hold and back-pressure rules from the main stepping.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  typedef enum logic [1:0] {
    SCAN_ROW = 2'd0,
    SCAN_COL = 2'd1
  } scan_e;
endpackage

// File: rtl/dwa_axis.sv
module dwa_axis #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  input  logic         step,
  output logic [W-1:0] ptr,
  output logic         at_last
);
  logic [W-1:0] lo_q, hi_q, ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '1;
      ptr_q <= '0;
    end else if (load) begin
      lo_q  <= lo_in;
      hi_q  <= hi_in;
      ptr_q <= lo_in;
    end else if (step) begin
      ptr_q <= (ptr_q == hi_q) ? lo_q : ptr_q + W'(1);
    end
  end

  assign ptr     = ptr_q;
  assign at_last = (ptr_q == hi_q);
endmodule

// File: rtl/dwa_mode.sv
module dwa_mode
  import dwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_set,
  input  logic [1:0] mode_sel,
  output scan_e      mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SCAN_ROW;
    else if (mode_set) begin
      if (mode_sel == 2'd0)      mode_q <= SCAN_ROW;
      else if (mode_sel == 2'd1) mode_q <= SCAN_COL;
    end
  end
endmodule

// File: rtl/dwa_step.sv
module dwa_step
  import dwa_pkg::*;
(
  input  scan_e mode,
  input  logic  accept,
  input  logic  col_last,
  input  logic  pg_last,
  output logic  col_step,
  output logic  pg_step
);
  always_comb begin
    col_step = 1'b0;
    pg_step  = 1'b0;
    if (accept) begin
      if (mode == SCAN_COL) begin
        pg_step  = 1'b1;
        col_step = pg_last;
      end else begin
        col_step = 1'b1;
        pg_step  = col_last;
      end
    end
  end
endmodule

// File: rtl/disp_wr_addr_gen.sv
module disp_wr_addr_gen
  import dwa_pkg::*;
#(
  parameter int COL_W  = 7,
  parameter int PG_W   = 3,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   col_set,
  input  logic [COL_W-1:0]       col_start,
  input  logic [COL_W-1:0]       col_end,
  input  logic                   pg_set,
  input  logic [PG_W-1:0]        pg_start,
  input  logic [PG_W-1:0]        pg_end,
  input  logic                   mode_set,
  input  logic [1:0]             mode_sel,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   ram_we,
  output logic [COL_W+PG_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]      ram_wdata
);
  localparam int ADDR_W = COL_W + PG_W;

  scan_e             mode_q;
  logic              accept, col_step, pg_step, col_last, pg_last;
  logic [COL_W-1:0]  col_ptr;
  logic [PG_W-1:0]   pg_ptr;

  assign wr_ready = !(col_set || pg_set || mode_set);
  assign accept   = wr_valid && wr_ready;

  dwa_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set),
    .mode_sel(mode_sel), .mode_q(mode_q)
  );

  dwa_step u_step (
    .mode(mode_q), .accept(accept), .col_last(col_last),
    .pg_last(pg_last), .col_step(col_step), .pg_step(pg_step)
  );

  dwa_axis #(.W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(col_set), .lo_in(col_start),
    .hi_in(col_end), .step(col_step), .ptr(col_ptr), .at_last(col_last)
  );

  dwa_axis #(.W(PG_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .load(pg_set), .lo_in(pg_start),
    .hi_in(pg_end), .step(pg_step), .ptr(pg_ptr), .at_last(pg_last)
  );

  assign ram_we    = accept;
  assign ram_wdata = wr_data;
  assign ram_addr  = ADDR_W'({pg_ptr, col_ptr});
endmodule

// File: rtl/disp_wr_addr_chk.sv
module disp_wr_addr_chk #(
  parameter int COL_W = 7,
  parameter int PG_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  col_set,
  input logic [COL_W-1:0]      col_start,
  input logic                  pg_set,
  input logic [PG_W-1:0]       pg_start,
  input logic                  mode_set,
  input logic                  ram_we,
  input logic [COL_W+PG_W-1:0] ram_addr,
  input logic [1:0]            mode_q,
  input logic                  col_last,
  input logic                  pg_last
);
  localparam int ADDR_W = COL_W + PG_W;

  // R2
  col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_set |=> ram_addr[COL_W-1:0] == $past(col_start));

  // R3
  pg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_set |=> ram_addr[ADDR_W-1:COL_W] == $past(pg_start));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mode_q == 2'd0 && !col_last && ram_addr[COL_W-1:0] != '1)
      |=> ram_addr == $past(ram_addr) + ADDR_W'(1));

  // R5
  col_order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mode_q == 2'd1 && !pg_last)
      |=> (ram_addr[COL_W-1:0] == $past(ram_addr[COL_W-1:0])) &&
          (ram_addr[ADDR_W-1:COL_W] == $past(ram_addr[ADDR_W-1:COL_W]) + PG_W'(1)));

  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_set || pg_set || mode_set) |-> !ram_we);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we && !col_set && !pg_set) |=> $stable(ram_addr));
endmodule

bind disp_wr_addr_gen disp_wr_addr_chk #(.COL_W(COL_W), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .col_set(col_set), .col_start(col_start),
  .pg_set(pg_set), .pg_start(pg_start), .mode_set(mode_set),
  .ram_we(ram_we), .ram_addr(ram_addr), .mode_q(mode_q),
  .col_last(col_last), .pg_last(pg_last)
);

// File: tb/sim_disp_wr_addr_gen.sv
module sim_disp_wr_addr_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic col_set = 0, pg_set = 0, mode_set = 0, wr_valid = 0;
  logic [6:0] col_start = 0, col_end = 0;
  logic [2:0] pg_start = 0, pg_end = 0;
  logic [1:0] mode_sel = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, ram_we;
  logic [9:0] ram_addr;
  logic [7:0] ram_wdata;

  int total = 0, bad = 0;
  logic [17:0] exp_q[$];
  string tag_q[$];

  // bench model
  logic [6:0] m_col = 0, m_clo = 0, m_chi = 7'd127;
  logic [2:0] m_pg = 0, m_plo = 0, m_phi = 3'd7;
  logic m_vert = 0;

  always #(PERIOD/2) clk = ~clk;

  disp_wr_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .col_set(col_set), .col_start(col_start),
    .col_end(col_end), .pg_set(pg_set), .pg_start(pg_start), .pg_end(pg_end),
    .mode_set(mode_set), .mode_sel(mode_sel), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_adv();
    if (!m_vert) begin
      if (m_col == m_chi) begin
        m_col = m_clo;
        if (m_pg == m_phi) m_pg = m_plo; else m_pg = m_pg + 3'd1;
      end else m_col = m_col + 7'd1;
    end else begin
      if (m_pg == m_phi) begin
        m_pg = m_plo;
        if (m_col == m_chi) m_col = m_clo; else m_col = m_col + 7'd1;
      end else m_pg = m_pg + 3'd1;
    end
  endtask

  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_valid = 1'b1;
      wr_data  = 8'(i * 7 + 3);
      exp_q.push_back({m_pg, m_col, wr_data});
      tag_q.push_back(tag);
      model_adv();
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  // R9: strobes presented together with a byte; byte must wait
  task automatic cfg(input bit c, input bit p, input bit m,
                     input logic [6:0] clo, input logic [6:0] chi,
                     input logic [2:0] plo, input logic [2:0] phi,
                     input logic [1:0] md);
    @(posedge clk); #1;
    col_set = c; pg_set = p; mode_set = m;
    col_start = clo; col_end = chi; pg_start = plo; pg_end = phi; mode_sel = md;
    wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk);
    chk(!wr_ready && !ram_we, "R9 stall during config", {wr_ready, ram_we}, 0);
    @(posedge clk); #1;
    col_set = 0; pg_set = 0; mode_set = 0; wr_valid = 1'b0;
    if (c) begin m_clo = clo; m_chi = chi; m_col = clo; end
    if (p) begin m_plo = plo; m_phi = phi; m_pg = plo; end
    if (m && md == 2'd0) m_vert = 1'b0;
    if (m && md == 2'd1) m_vert = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected write", {ram_addr, ram_wdata}, 0);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({ram_addr, ram_wdata} == e, t, {ram_addr, ram_wdata}, e);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset: ready, no write, address 0
    chk(wr_ready && !ram_we, "R8 reset ready", {wr_ready, ram_we}, 2);
    chk(ram_addr == 10'd0, "R8 reset address", ram_addr, 0);
    // R1 R8 R4: first bytes from reset in row order
    burst(3, "R1 R8 first bytes");
    // R10: idle gaps between single bytes
    repeat (4) @(posedge clk);
    burst(1, "R10 after gap");
    repeat (3) @(posedge clk);
    burst(1, "R10 after gap");
    // R4 R6: full screen row order, ends with both wraps
    cfg(1, 1, 0, 7'd0, 7'd127, 3'd0, 3'd7, 2'd0);
    burst(1024, "R4 R6 full screen");
    burst(2, "R6 wrapped to zero");
    // R2 R3 R4 R6: small window row order
    cfg(1, 0, 0, 7'd10, 7'd13, 3'd0, 3'd0, 2'd0);
    cfg(0, 1, 0, 7'd0, 7'd0, 3'd2, 3'd3, 2'd0);
    burst(12, "R2 R3 R4 window row order");
    // R5 R7: column order, window at right edge
    cfg(0, 0, 1, 7'd0, 7'd0, 3'd0, 3'd0, 2'd1);
    cfg(1, 1, 0, 7'd120, 7'd127, 3'd5, 3'd7, 2'd0);
    burst(30, "R5 column order");
    // R7: unsupported code keeps column order
    cfg(0, 0, 1, 7'd0, 7'd0, 3'd0, 3'd0, 2'd2);
    burst(5, "R7 code 2 ignored");
    cfg(0, 0, 1, 7'd0, 7'd0, 3'd0, 3'd0, 2'd3);
    burst(4, "R7 code 3 ignored");
    // R6: single-address window
    cfg(1, 1, 0, 7'd77, 7'd77, 3'd4, 3'd4, 2'd0);
    burst(3, "R6 single address");
    // R7: back to row order
    cfg(0, 0, 1, 7'd0, 7'd0, 3'd0, 3'd0, 2'd0);
    cfg(1, 1, 0, 7'd126, 7'd127, 3'd6, 3'd7, 2'd0);
    burst(6, "R7 row order again");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R1 all writes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule